// File: doc/BRIEF.md
# Clock-Register Command Slave for a Serial Peripheral Bus

This block lets a host reach the clock-calendar register file over a four-wire serial bus in mode 0: SCK idles low, MOSI is taken on the rising edge and MISO moves after the falling edge, most significant bit first. Every frame, bounded by chip select going low and then high, opens with an instruction byte. A clock-register read instruction or a clock-register write instruction is followed by a one-byte start address and then by data bytes. The address moves up by one for each data byte. The registers themselves live in the calendar block. This slave only looks at them through a combinational read port and changes them through a byte-wide write strobe.

SCK, chip select and MOSI are brought into the system clock domain through a short synchronizer chain. A single state machine then tracks the frame. The states are ST_OPCODE (waiting for the instruction), ST_RD_ADDR and ST_WR_ADDR (taking the start address), ST_RD_DATA (streaming registers out), ST_WR_DATA (committing received bytes) and ST_IGNORE (instruction recognised but without effect here). The transitions are as follows:
- A completed instruction byte moves ST_OPCODE to ST_RD_ADDR for 0x13, to ST_WR_ADDR for 0x12, and to ST_IGNORE for every other value.
- A completed address byte moves ST_RD_ADDR to ST_RD_DATA and ST_WR_ADDR to ST_WR_DATA.
- Chip select going high returns every state to ST_OPCODE.

Top module: `rtcc_spi_slave`

## Requirements
- R1: Mode-0 timing. MOSI bits are taken on rising SCK, most significant bit first. MISO changes only after falling SCK, so the host can sample it on the next rising edge.
- R2: Instruction 0x13 followed by address A returns, on MISO, the register at A, then A+1, A+2, and so on, one byte per eight SCK cycles.
- R3: Instruction 0x12 followed by address A gives exactly one single-cycle pulse of reg_wr_en for each complete data byte. The pulse carries that byte on reg_wr_data and A, A+1, … on reg_wr_addr.
- R4: The address wraps from 0xFF to 0x00 within a burst, for both reads and writes.
- R5: A write burst of 255 data bytes commits all 255 bytes, at consecutive addresses.
- R6: The instructions 0x01, 0x02, 0x03, 0x04, 0x05, 0x06, 0x14, 0x32, 0x33, 0x44 and 0x54 are accepted. They produce no write pulse, and MISO stays 0 for the rest of the frame.
- R7: Any other instruction value that is neither 0x12 nor 0x13 is treated in the same way as the values in R6.
- R8: Raising chip select discards any partly shifted byte, and no write pulse is produced for it. The next frame starts again with an instruction byte.
- R9: MISO is 0 and miso_oe is 0 while chip select is high and during the instruction and address bytes. miso_oe is 1 during the read data phase.
- R10: After reset the block is in ST_OPCODE, with miso, miso_oe and reg_wr_en all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, used to oversample the serial lines |
| rst_n | input | 1 | Asynchronous reset, active low |
| sck | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host, 0 when not reading |
| miso_oe | output | 1 | High while MISO carries register data |
| reg_rd_addr | output | 8 | Address presented to the register file |
| reg_rd_data | input | 8 | Register contents at reg_rd_addr, combinational |
| reg_wr_en | output | 1 | Single-cycle write strobe |
| reg_wr_addr | output | 8 | Address for the write strobe |
| reg_wr_data | output | 8 | Data for the write strobe |

## Verification
On every cycle, the embedded assertions check the following:
- Write pulses come only out of the write data state.
- The address steps by one, modulo 256, on every committed byte.
- The ignore state never produces a pulse.
- Chip select going high always returns the machine and the receive counter to idle.
- MISO stays low whenever it carries no register data.

Only the bench scenarios can show the following:
- The read data actually matches the register file at the right addresses, in the right bit order.
- The full 255-byte burst lands intact.
- An aborted frame leaves the registers untouched.

// File: rtl/rtcc_spi_pkg.sv
package rtcc_spi_pkg;

    typedef enum logic [2:0] {
        ST_OPCODE,
        ST_RD_ADDR,
        ST_WR_ADDR,
        ST_RD_DATA,
        ST_WR_DATA,
        ST_IGNORE
    } spi_state_e;

    // Clock-register instructions handled here
    localparam logic [7:0] OP_CLK_READ  = 8'h13;
    localparam logic [7:0] OP_CLK_WRITE = 8'h12;
    // Instructions recognised but without effect in this block
    localparam logic [7:0] OP_NV_READ   = 8'h03;
    localparam logic [7:0] OP_NV_WRITE  = 8'h02;
    localparam logic [7:0] OP_NV_LOCK   = 8'h04;
    localparam logic [7:0] OP_NV_OPEN   = 8'h06;
    localparam logic [7:0] OP_STS_READ  = 8'h05;
    localparam logic [7:0] OP_STS_WRITE = 8'h01;
    localparam logic [7:0] OP_KEY_SEQ   = 8'h14;
    localparam logic [7:0] OP_TAG_WRITE = 8'h32;
    localparam logic [7:0] OP_TAG_READ  = 8'h33;
    localparam logic [7:0] OP_DOG_KICK  = 8'h44;
    localparam logic [7:0] OP_SRAM_WIPE = 8'h54;

    function automatic spi_state_e decode_opcode(input logic [7:0] op);
        spi_state_e nxt;
        unique case (op)
            OP_CLK_READ:  nxt = ST_RD_ADDR;
            OP_CLK_WRITE: nxt = ST_WR_ADDR;
            OP_NV_READ, OP_NV_WRITE, OP_NV_LOCK, OP_NV_OPEN,
            OP_STS_READ, OP_STS_WRITE, OP_KEY_SEQ, OP_TAG_WRITE,
            OP_TAG_READ, OP_DOG_KICK, OP_SRAM_WIPE:
                          nxt = ST_IGNORE;
            default:      nxt = ST_IGNORE;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/rtcc_spi_sync.sv
module rtcc_spi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck,
    input  logic cs_n,
    input  logic mosi,
    output logic sel,
    output logic sck_rise,
    output logic sck_fall,
    output logic mosi_s
);
    localparam int LAST = STAGES - 1;

    logic [LAST:0] sck_ff;
    logic [LAST:0] csn_ff;
    logic [LAST:0] mosi_ff;
    logic          sck_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_ff   <= '0;
            csn_ff   <= '1;
            mosi_ff  <= '0;
            sck_prev <= 1'b0;
        end else begin
            sck_ff[0]  <= sck;
            csn_ff[0]  <= cs_n;
            mosi_ff[0] <= mosi;
            for (int i = 1; i < STAGES; i++) begin
                sck_ff[i]  <= sck_ff[i-1];
                csn_ff[i]  <= csn_ff[i-1];
                mosi_ff[i] <= mosi_ff[i-1];
            end
            sck_prev <= sck_ff[LAST];
        end
    end

    assign sel      = !csn_ff[LAST];
    assign mosi_s   = mosi_ff[LAST];
    assign sck_rise = sel && sck_ff[LAST] && !sck_prev;
    assign sck_fall = sel && !sck_ff[LAST] && sck_prev;

endmodule

// File: rtl/rtcc_spi_rx.sv
module rtcc_spi_rx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              rise,
    input  logic              mosi_s,
    output logic              byte_vld,
    output logic [DATA_W-1:0] byte_q
);
    localparam int CW = $clog2(DATA_W);

    logic [DATA_W-1:0] shreg;
    logic [CW-1:0]     cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg    <= '0;
            cnt      <= '0;
            byte_vld <= 1'b0;
            byte_q   <= '0;
        end else if (!sel) begin
            cnt      <= '0;
            byte_vld <= 1'b0;
        end else begin
            byte_vld <= 1'b0;
            if (rise) begin
                shreg <= {shreg[DATA_W-2:0], mosi_s};
                if (cnt == CW'(DATA_W - 1)) begin
                    cnt      <= '0;
                    byte_q   <= {shreg[DATA_W-2:0], mosi_s};
                    byte_vld <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    AST_RX_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> (cnt == '0) && !byte_vld); // R8

endmodule

// File: rtl/rtcc_spi_tx.sv
module rtcc_spi_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              fall,
    input  logic [DATA_W-1:0] load_data,
    output logic              fetch,
    output logic              miso
);
    localparam int CW = $clog2(DATA_W);

    logic [DATA_W-1:0] shreg;
    logic [CW-1:0]     cnt;

    assign fetch = active && fall && (cnt == '0);
    assign miso  = shreg[DATA_W-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (!active) begin
            shreg <= '0;
            cnt   <= '0;
        end else if (fall) begin
            if (cnt == '0) shreg <= load_data;
            else           shreg <= {shreg[DATA_W-2:0], 1'b0};
            cnt <= (cnt == CW'(DATA_W - 1)) ? '0 : cnt + 1'b1;
        end
    end

    AST_TX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !miso); // R9

endmodule

// File: rtl/rtcc_spi_slave.sv
module rtcc_spi_slave
    import rtcc_spi_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              cs_n,
    input  logic              mosi,
    output logic              miso,
    output logic              miso_oe,
    output logic [DATA_W-1:0] reg_rd_addr,
    input  logic [DATA_W-1:0] reg_rd_data,
    output logic              reg_wr_en,
    output logic [DATA_W-1:0] reg_wr_addr,
    output logic [DATA_W-1:0] reg_wr_data
);
    localparam int ADDR_W = DATA_W;

    logic              sel, sck_rise, sck_fall, mosi_s;
    logic              byte_vld, fetch, tx_active;
    logic [DATA_W-1:0] byte_q;
    logic [ADDR_W-1:0] addr_q;
    spi_state_e        state_q, state_d;

    rtcc_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .sel(sel), .sck_rise(sck_rise), .sck_fall(sck_fall), .mosi_s(mosi_s)
    );

    rtcc_spi_rx #(.DATA_W(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .sel(sel), .rise(sck_rise),
        .mosi_s(mosi_s), .byte_vld(byte_vld), .byte_q(byte_q)
    );

    assign tx_active = sel && (state_q == ST_RD_DATA);

    rtcc_spi_tx #(.DATA_W(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .active(tx_active), .fall(sck_fall),
        .load_data(reg_rd_data), .fetch(fetch), .miso(miso)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OPCODE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (!sel) begin
            state_d = ST_OPCODE;
        end else if (byte_vld) begin
            unique case (state_q)
                ST_OPCODE:  state_d = decode_opcode(byte_q[7:0]);
                ST_RD_ADDR: state_d = ST_RD_DATA;
                ST_WR_ADDR: state_d = ST_WR_DATA;
                ST_RD_DATA, ST_WR_DATA, ST_IGNORE: state_d = state_q;
                default:    state_d = ST_OPCODE;
            endcase
        end
    end

    // Address pointer and write strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q      <= '0;
            reg_wr_en   <= 1'b0;
            reg_wr_addr <= '0;
            reg_wr_data <= '0;
        end else begin
            reg_wr_en <= 1'b0;
            if (byte_vld && (state_q == ST_RD_ADDR || state_q == ST_WR_ADDR)) begin
                addr_q <= byte_q[ADDR_W-1:0];
            end else if (byte_vld && state_q == ST_WR_DATA) begin
                reg_wr_en   <= 1'b1;
                reg_wr_addr <= addr_q;
                reg_wr_data <= byte_q;
                addr_q      <= addr_q + 1'b1;
            end else if (fetch) begin
                addr_q <= addr_q + 1'b1;
            end
        end
    end

    assign reg_rd_addr = addr_q;
    assign miso_oe     = tx_active;

    AST_WR_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> $past(state_q == ST_WR_DATA)); // R3
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && state_q == ST_WR_DATA) |=> (addr_q == $past(addr_q) + 1'b1)); // R4
    AST_IGNORE_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IGNORE) |=> !reg_wr_en); // R6
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> (state_q == ST_OPCODE)); // R8
    AST_ADDR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RD_ADDR || state_q == ST_OPCODE) |-> !miso && !miso_oe); // R9

endmodule

// File: tb/rtcc_spi_slave_test.sv
`timescale 1ns/1ps
module rtcc_spi_slave_test;

    localparam int H = 8;  // SCK half period in clk cycles

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic       miso, miso_oe, reg_wr_en;
    logic [7:0] reg_rd_addr, reg_rd_data, reg_wr_addr, reg_wr_data;

    logic [7:0] mem    [256];
    logic [7:0] shadow [256];
    int         wr_count = 0;
    logic [7:0] last_wr_addr = '0;
    int         quiet_viol = 0;
    logic       watch = 1'b0;
    int         checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    rtcc_spi_slave uut (
        .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe), .reg_rd_addr(reg_rd_addr),
        .reg_rd_data(reg_rd_data), .reg_wr_en(reg_wr_en),
        .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data)
    );

    assign reg_rd_data = mem[reg_rd_addr];

    // Register file model: filled during reset, written by the strobe
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
        end else if (reg_wr_en) begin
            mem[reg_wr_addr] = reg_wr_data;
            wr_count         = wr_count + 1;
            last_wr_addr     = reg_wr_addr;
        end
    end

    always @(negedge clk) if (watch && miso) quiet_viol = quiet_viol + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_bits(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = '0;
        for (int b = 7; b > 7 - nbits; b--) begin
            mosi = tx[b];
            wait_clk(H);
            rx[b] = miso;       // host samples just before rising SCK
            sck = 1'b1;
            wait_clk(H);
            sck = 1'b0;
        end
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        spi_bits(tx, 8, rx);
    endtask

    task automatic frame_begin;
        cs_n = 1'b0;
        wait_clk(H);
    endtask

    task automatic frame_end;
        wait_clk(H);
        cs_n = 1'b1;
        wait_clk(2 * H);
    endtask

    task automatic do_write(input logic [7:0] a, input int n, input logic [7:0] seed);
        logic [7:0] r;
        int base;
        int bad;
        base = wr_count;
        frame_begin;
        spi_byte(8'h12, r);
        spi_byte(a, r);
        for (int i = 0; i < n; i++) begin
            spi_byte(8'(seed + i), r);
            shadow[8'(a + i)] = 8'(seed + i);
        end
        frame_end;
        chk(wr_count - base == n, "R3 strobe count", wr_count - base, n);
        bad = 0;
        for (int i = 0; i < n; i++) if (mem[8'(a + i)] !== shadow[8'(a + i)]) bad++;
        chk(bad == 0, "R3/R4 written bytes", bad, 0);
    endtask

    task automatic do_read(input logic [7:0] a, input int n);
        logic [7:0] r;
        int v0;
        frame_begin;
        v0 = quiet_viol;
        watch = 1'b1;
        spi_byte(8'h13, r);
        chk(miso_oe == 1'b0, "R9 oe low after instruction", miso_oe, 0);
        spi_byte(a, r);
        watch = 1'b0;
        chk(quiet_viol == v0, "R9 miso quiet in header", quiet_viol - v0, 0);
        for (int i = 0; i < n; i++) begin
            spi_byte(8'hFF, r);
            if (i == 0) chk(miso_oe == 1'b1, "R9 oe high in data", miso_oe, 1);
            chk(r == shadow[8'(a + i)], "R1/R2/R4 read byte", r, shadow[8'(a + i)]);
        end
        frame_end;
    endtask

    // {is_write, addr, count, seed}
    localparam int NV = 7;
    localparam logic [25:0] VEC [NV] = '{
        {1'b1, 8'h10, 9'd3, 8'hA0},
        {1'b0, 8'h10, 9'd3, 8'h00},
        {1'b1, 8'hFE, 9'd4, 8'hC0},
        {1'b0, 8'hFE, 9'd4, 8'h00},
        {1'b0, 8'h00, 9'd1, 8'h00},
        {1'b1, 8'h7F, 9'd2, 8'h33},
        {1'b0, 8'h7E, 9'd4, 8'h00}
    };

    localparam int NIG = 14;
    localparam logic [7:0] IGN [NIG] = '{
        8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h14,
        8'h32, 8'h33, 8'h44, 8'h54, 8'h00, 8'hFF, 8'h7E
    };

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] r;
        int base, v0, bad;
        for (int i = 0; i < 256; i++) shadow[i] = 8'(i) ^ 8'h5A;
        wait_clk(5);
        // R10: reset state
        chk(miso == 1'b0 && miso_oe == 1'b0 && reg_wr_en == 1'b0, "R10 reset outputs",
            {miso, miso_oe, reg_wr_en}, 0);
        rst_n = 1'b1;
        wait_clk(4);
        chk(miso == 1'b0 && miso_oe == 1'b0, "R10 idle after reset", {miso, miso_oe}, 0);

        // Table walk: R2 R3 R4
        for (int v = 0; v < NV; v++) begin
            if (VEC[v][25]) do_write(VEC[v][24:17], int'(VEC[v][16:8]), VEC[v][7:0]);
            else            do_read(VEC[v][24:17], int'(VEC[v][16:8]));
        end

        // R6 / R7: ignored instructions
        for (int k = 0; k < NIG; k++) begin
            base = wr_count;
            bad  = 0;
            frame_begin;
            v0 = quiet_viol;
            watch = 1'b1;
            spi_byte(IGN[k], r);
            spi_byte(8'h20, r);
            spi_byte(8'h55, r); bad += (r != 0);
            spi_byte(8'hAA, r); bad += (r != 0);
            watch = 1'b0;
            frame_end;
            chk(wr_count == base && bad == 0 && quiet_viol == v0 && mem[8'h20] == shadow[8'h20],
                (k < 11) ? "R6 ignored instruction" : "R7 unknown instruction",
                wr_count - base + bad + quiet_viol - v0, 0);
        end

        // R8: abort inside a data byte
        base = wr_count;
        frame_begin;
        spi_byte(8'h12, r);
        spi_byte(8'h50, r);
        spi_bits(8'hAA, 5, r);
        frame_end;
        chk(wr_count == base, "R8 partial byte dropped", wr_count - base, 0);
        chk(mem[8'h50] == shadow[8'h50], "R8 register untouched", mem[8'h50], shadow[8'h50]);
        do_write(8'h50, 1, 8'h99);  // R8 next frame starts with an instruction

        // R8: one full byte then a partial one
        base = wr_count;
        frame_begin;
        spi_byte(8'h12, r);
        spi_byte(8'h60, r);
        spi_byte(8'h3C, r);
        shadow[8'h60] = 8'h3C;
        spi_bits(8'hF0, 3, r);
        frame_end;
        chk(wr_count - base == 1, "R8 only full bytes commit", wr_count - base, 1);
        chk(mem[8'h60] == 8'h3C, "R8 full byte value", mem[8'h60], 8'h3C);

        // R5: longest burst, wrapping past 0xFF
        do_write(8'h80, 255, 8'h01);
        chk(last_wr_addr == 8'h7E, "R5/R4 last burst address", last_wr_addr, 8'h7E);
        do_read(8'hFD, 6);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule